// File: doc/BRIEF.md
# Bit and Byte Reversal Execution Unit

This unit executes the reversal part of a 64-bit processor's one-source data-processing group. Each cycle it may accept a 32-bit instruction word together with the operand already read from the source register. It checks the word against the exact encoding of the group and applies one of four permutations to the operand: a full bit reversal, a byte swap inside every halfword, a byte swap inside every word, or a byte swap across the whole doubleword.

A size bit in the word selects 64-bit or 32-bit operation. In 32-bit operation only the low word of the operand is used, and the result is zero-extended to 64 bits. A word that does not decode to a legal operation raises an undefined-instruction flag instead of producing a result. The destination index, the result and both strobes are registered and appear one clock after the input strobe.

Top module: `revperm_unit`

## Requirements
- R1: A word is legal only when bit 31 is the size flag (1 means 64-bit), bits 30:29 equal 2'b10, bits 28:21 equal 8'b11010110, bits 20:16 equal zero, and the opcode in bits 15:10 is 0, 1 or 2, or is 3 with the size flag set. Any other word accepted with `in_valid` sets `out_undef`, clears `out_valid` and drives `out_data` to zero.
- R2: `out_valid`, `out_undef`, `out_rd` (bits 4:0 of the word) and `out_data` appear on the clock edge after the one that samples `in_valid`.
- R3: A synchronous active-high `rst` clears `out_valid` and `out_undef`, even while `in_valid` is high.
- R4: Opcode 0 reverses the order of all 64 bits; with the size flag clear it reverses the low 32 bits and zeroes the upper 32.
- R5: Opcode 1 swaps the two bytes of every 16-bit halfword; with the size flag clear only the low word is processed and the upper 32 bits are zero.
- R6: Opcode 2 reverses the four bytes inside each 32-bit word in place; with the size flag clear the low word is processed and the upper 32 bits are zero.
- R7: Opcode 3 with the size flag set reverses all eight bytes; with the size flag clear it is undefined (no result, `out_undef` set).
- R8: `out_valid` and `out_undef` are never high together, and neither is high in a cycle that follows one without `in_valid`.
- R9: Applying any legal operation twice with the same size flag returns the original operand, zero-extended from the low word in 32-bit size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operand are present |
| in_insn | input | 32 | Instruction word |
| in_src | input | 64 | Operand read from the source register |
| out_valid | output | 1 | Result is present |
| out_undef | output | 1 | The accepted word was undefined |
| out_rd | output | 5 | Destination register index |
| out_data | output | 64 | Result |

## Verification
The result strobe and the undefined flag share one output stage, so a legal word and an illegal one issued on consecutive cycles must each own exactly one output cycle. The bench streams legal words back to back with undefined ones (a bad fixed field, a nonzero opcode2, opcode 4 and the 32-bit doubleword swap) and checks for each output cycle that exactly one strobe is high, that the result belongs to the word issued one cycle earlier, and that an undefined cycle carries zero data. Reset applied while a word is presented must suppress both strobes.

// File: rtl/revperm_unit.sv
module revperm_unit #(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     in_insn,
  input  logic [XLEN-1:0] in_src,
  output logic            out_valid,
  output logic            out_undef,
  output logic [IDX_W-1:0] out_rd,
  output logic [XLEN-1:0] out_data
);
  localparam int HALF   = XLEN / 2;
  localparam int NBYTES = XLEN / 8;

  logic       wide;
  logic [5:0] opc;
  logic       fixed_ok, legal;
  assign wide     = in_insn[31];
  assign opc      = in_insn[15:10];
  assign fixed_ok = (in_insn[30:29] == 2'b10) && (in_insn[28:21] == 8'b11010110)
                 && (in_insn[20:16] == 5'd0) && (opc[5:2] == 4'd0);
  assign legal    = fixed_ok && (opc[1:0] != 2'd3 || wide);

  logic [XLEN-1:0] rev_full, rev_low, swp_half, swp_word, swp_dbl;

  for (genvar i = 0; i < XLEN; i++) begin : g_rbit
    assign rev_full[i] = in_src[XLEN-1-i];
  end
  for (genvar i = 0; i < HALF; i++) begin : g_rbit_lo
    assign rev_low[i] = in_src[HALF-1-i];
  end
  assign rev_low[XLEN-1:HALF] = '0;

  for (genvar b = 0; b < NBYTES; b++) begin : g_bytes
    assign swp_half[8*b +: 8] = in_src[8*(b ^ 1) +: 8];
    assign swp_word[8*b +: 8] = in_src[8*((b / 4) * 4 + 3 - (b % 4)) +: 8];
    assign swp_dbl[8*b +: 8]  = in_src[8*(NBYTES-1-b) +: 8];
  end

  logic [XLEN-1:0] perm, result;
  always_comb begin
    case (opc[1:0])
      2'd0:    perm = wide ? rev_full : rev_low;
      2'd1:    perm = swp_half;
      2'd2:    perm = swp_word;
      default: perm = swp_dbl;
    endcase
  end
  assign result = !legal ? '0 : (wide ? perm : {{HALF{1'b0}}, perm[HALF-1:0]});

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_undef <= 1'b0;
    end else begin
      out_valid <= in_valid && legal;
      out_undef <= in_valid && !legal;
    end
    if (in_valid) begin
      out_rd   <= in_insn[IDX_W-1:0];
      out_data <= result;
    end
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_undef)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !out_undef); // R8
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid || out_undef)); // R2
  AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_rd == $past(in_insn[IDX_W-1:0])); // R2
  AST_UNDEF_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    out_undef |-> out_data == '0); // R1
  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_insn[31] |=> out_data[XLEN-1:HALF] == '0); // R4
  AST_DBL_NARROW_UNDEF: assert property (@(posedge clk) disable iff (rst)
    in_valid && fixed_ok && !in_insn[31] && in_insn[11:10] == 2'd3 |=> out_undef); // R7
endmodule

// File: tb/revperm_unit_tb.sv
`timescale 1ns/1ps
module revperm_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] in_insn = '0;
  logic [63:0] in_src = '0;
  logic out_valid, out_undef;
  logic [4:0] out_rd;
  logic [63:0] out_data;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  revperm_unit u_dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .in_src(in_src), .out_valid(out_valid), .out_undef(out_undef), .out_rd(out_rd),
    .out_data(out_data));

  // {size flag, opcode[1:0], operand}
  localparam logic [66:0] VEC [12] = '{
    {1'b1, 2'd0, 64'h0123456789ABCDEF}, {1'b0, 2'd0, 64'hFFFF0000_80000001},
    {1'b1, 2'd1, 64'h1122334455667788}, {1'b0, 2'd1, 64'hDEADBEEF_CAFEF00D},
    {1'b1, 2'd2, 64'h0011223344556677}, {1'b0, 2'd2, 64'h89ABCDEF_01234567},
    {1'b1, 2'd3, 64'h0102030405060708}, {1'b1, 2'd3, 64'hF000000000000001},
    {1'b1, 2'd0, 64'h8000000000000000}, {1'b0, 2'd0, 64'h00000000_00000001},
    {1'b1, 2'd1, 64'hFF00FF00FF00FF00}, {1'b0, 2'd2, 64'hAAAAAAAA_000000FF}};

  function automatic logic [31:0] mk(bit sf, logic [5:0] op, logic [4:0] rn, logic [4:0] rd);
    return {sf, 2'b10, 8'b11010110, 5'd0, op, rn, rd};
  endfunction

  function automatic logic [63:0] model(bit sf, int op, logic [63:0] x);
    logic [63:0] r = '0;
    logic [63:0] m = sf ? 64'h00FF00FF00FF00FF : 64'h00FF00FF;
    if (!sf) x = x & 64'hFFFFFFFF;
    case (op)
      0: if (sf) for (int i = 0; i < 64; i++) r[i] = x[63-i];
         else    for (int i = 0; i < 32; i++) r[i] = x[31-i];
      1: r = ((x & m) << 8) | ((x >> 8) & m);
      2: if (sf) for (int b = 0; b < 8; b++) r[8*b +: 8] = x[8*((b/4)*4 + 3 - b%4) +: 8];
         else r = {32'd0, x[7:0], x[15:8], x[23:16], x[31:24]};
      default: r = {<<8{x}};
    endcase
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] w, logic [63:0] x);
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_src = x;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_undef(string req);
    chk(out_undef && !out_valid, req, {62'd0, out_valid, out_undef}, 64'd1);
    chk(out_data == 64'd0, req, out_data, 64'd0);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] y, z, x0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_undef, "R3 reset", {62'd0, out_valid, out_undef}, 64'd0);
    rst = 1'b0;

    foreach (VEC[i]) begin
      bit sf = VEC[i][66];
      int op = int'(VEC[i][65:64]);
      string tag = op == 0 ? "R4" : op == 1 ? "R5" : op == 2 ? "R6" : "R7";
      issue(mk(sf, 6'(op), 5'(i + 1), 5'(i)), VEC[i][63:0]);
      chk(out_valid && !out_undef, "R2 strobe", {62'd0, out_valid, out_undef}, 64'd2);
      chk(out_rd == 5'(i), "R2 rd", 64'(out_rd), 64'(i));
      y = model(sf, op, VEC[i][63:0]);
      chk(out_data == y, tag, out_data, y);
      issue(mk(sf, 6'(op), 5'd2, 5'd3), out_data);
      x0 = sf ? VEC[i][63:0] : {32'd0, VEC[i][31:0]};
      chk(out_data == x0, "R9 involution", out_data, x0);
    end

    issue(mk(1'b0, 6'd3, 5'd1, 5'd2), 64'h0102030405060708);
    expect_undef("R7 narrow dbl swap");
    issue(mk(1'b1, 6'd4, 5'd1, 5'd2), 64'h1);
    expect_undef("R1 opcode 4");
    issue(mk(1'b1, 6'd0, 5'd1, 5'd2) ^ 32'h4000_0000, 64'h1);
    expect_undef("R1 bit30");
    issue(mk(1'b1, 6'd1, 5'd1, 5'd2) | 32'h0001_0000, 64'h1);
    expect_undef("R1 opcode2");
    issue(mk(1'b1, 6'd0, 5'd1, 5'd2) ^ 32'h0020_0000, 64'h1);
    expect_undef("R1 bit21");

    // back to back: legal, undefined, legal
    @(negedge clk);
    in_valid = 1'b1; in_insn = mk(1'b1, 6'd3, 5'd1, 5'd7); in_src = 64'h0102030405060708;
    @(negedge clk);
    chk(out_valid && !out_undef && out_rd == 5'd7, "R8 b2b first", {59'd0, out_rd}, 64'd7);
    chk(out_data == 64'h0807060504030201, "R7 b2b", out_data, 64'h0807060504030201);
    in_insn = mk(1'b0, 6'd3, 5'd1, 5'd9);
    @(negedge clk);
    chk(out_undef && !out_valid && out_rd == 5'd9, "R8 b2b second", {59'd0, out_rd}, 64'd9);
    in_insn = mk(1'b0, 6'd1, 5'd1, 5'd4); in_src = 64'hFFFFFFFF_AABBCCDD;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && !out_undef, "R8 b2b third", {62'd0, out_valid, out_undef}, 64'd2);
    chk(out_data == 64'h00000000_BBAADDCC, "R5 b2b", out_data, 64'h00000000_BBAADDCC);

    // illegal word without strobe: no flag
    in_insn = 32'hFFFF_FFFF;
    @(negedge clk);
    @(negedge clk);
    chk(!out_valid && !out_undef, "R8 idle", {62'd0, out_valid, out_undef}, 64'd0);

    // reset while presenting a word
    in_valid = 1'b1; in_insn = mk(1'b1, 6'd0, 5'd1, 5'd2); rst = 1'b1;
    @(negedge clk);
    chk(!out_valid && !out_undef, "R3 reset with strobe", {62'd0, out_valid, out_undef}, 64'd0);
    in_valid = 1'b0; rst = 1'b0;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule